// File: doc/BRIEF.md
# Banked Distributor Control Register

This block holds the 32-bit control word of an interrupt distributor: the enables for the three interrupt groups, the two routing-mode enables, the flag that turns the two-state security model off, and a write-pending status bit. A register bus writes and reads it. Each write and each read carries a secure attribute. What a caller may change, and what it sees, depends on that attribute and on whether security has been turned off.

Turning security off can only be done by a secure write while security is still on. It is permanent until reset. The same write clears the secure group-1 enable and the non-secure routing enable. Every write, including one that changes nothing, gives a one-cycle pulse. The neighbouring update logic uses this pulse to start a full re-evaluation of pending interrupts. The group enables and the security-off flag are also driven straight out as level signals.

Top module: `dist_ctl_reg`

## Requirements
- R1: After a synchronous reset all group enables and the security-off flag are 0, a secure read returns 0x0000_0030, and upd_pulse is 0.
- R2: With security on, a secure write loads bits 0 (group-0 enable), 1 (group-1 non-secure enable) and 2 (group-1 secure enable) from wr_data, and leaves every other stored bit except bit 6 unchanged.
- R3: With security on, a non-secure write changes only bit 1. Bits 0, 2 and 6 keep their values.
- R4: With security on, a non-secure read returns only bits 1 and 4 and bit 31 of the stored word. Every other bit reads 0.
- R5: A secure write with bit 6 set while security is on sets the security-off flag. In the same update it clears bit 2 and bit 5 (non-secure routing enable), even if the write also carries a 1 in bit 2.
- R6: While security is off, only bits 0 and 1 are writable, from either attribute. Writing 0 to bit 6 does not clear the flag, and writing bit 2 has no effect. Only reset clears the flag.
- R7: While security is off, reads from both attributes return the full stored word, which has only bits 0, 1, 4 and 6 able to be set.
- R8: Bit 4 (secure routing enable) always reads 1. Bit 5 reads 1 on a secure read while security is on.
- R9: upd_pulse is high for exactly the one cycle after each clock edge that captures a write (wr_en high), whatever the write changed, and low otherwise.
- R10: Bit 31 (write pending) and bits 3 and 7 to 30 always read 0, whatever is written.
- R11: grp0_en, grp1ns_en, grp1s_en and sec_off always equal stored bits 0, 1, 2 and 6, and change on the same edge as the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| wr_secure | input | 1 | Secure attribute of the write |
| wr_data | input | 32 | Write data |
| rd_secure | input | 1 | Secure attribute of the read |
| rd_data | output | 32 | Read view of the register (combinational from state and rd_secure) |
| upd_pulse | output | 1 | One-cycle pulse after every write |
| grp0_en | output | 1 | Group-0 enable |
| grp1ns_en | output | 1 | Group-1 non-secure enable |
| grp1s_en | output | 1 | Group-1 secure enable |
| sec_off | output | 1 | Security-disabled flag |

## Verification
The bench targets the write that sets the security-off flag while also writing 1 to bit 2. A design that applies the clear before the load, instead of after it, would leave the secure group-1 enable on. It also tries to clear the flag with a later write. A design that kept bit 6 in the write mask would drop back into the two-state view, so reads from both attributes would change.

Non-secure writes of all-ones and of all-zeros with security on catch a mask that is too wide, because group-0 or the secure enable would move. Non-secure reads catch a view that leaks bits 0, 2 or 5. A write that changes nothing must still pulse, so a design that only pulses on a change fails there.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

    localparam int unsigned DATA_W  = 32;

    // bit positions the neighbouring update logic decodes
    localparam int unsigned B_G0    = 0;
    localparam int unsigned B_G1NS  = 1;
    localparam int unsigned B_G1S   = 2;
    localparam int unsigned B_ARES  = 4;
    localparam int unsigned B_ARENS = 5;
    localparam int unsigned B_SOFF  = 6;
    localparam int unsigned B_PEND  = DATA_W - 1;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,   // security turned off
        MODE_SEC    = 2'd1,   // two states, secure access
        MODE_NSEC   = 2'd2    // two states, non-secure access
    } acc_mode_t;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic g0;
        logic g1ns;
        logic g1s;
        logic soff;
    } ctl_flags_t;

    function automatic word_t bitw(input int unsigned pos);
        word_t w;
        w = '0;
        w[pos] = 1'b1;
        return w;
    endfunction

    function automatic acc_mode_t classify(input logic soff, input logic secure);
        if (soff)        return MODE_SINGLE;
        else if (secure) return MODE_SEC;
        else             return MODE_NSEC;
    endfunction

    function automatic word_t write_mask(input acc_mode_t m);
        case (m)
            MODE_SINGLE: return bitw(B_G0) | bitw(B_G1NS);
            MODE_SEC:    return bitw(B_G0) | bitw(B_G1NS) | bitw(B_G1S) | bitw(B_SOFF);
            default:     return bitw(B_G1NS);
        endcase
    endfunction

    function automatic word_t view_mask(input acc_mode_t m);
        if (m == MODE_NSEC) return bitw(B_PEND) | bitw(B_ARES) | bitw(B_G1NS);
        else                return '1;
    endfunction

    function automatic word_t reset_image();
        return bitw(B_ARES) | bitw(B_ARENS);
    endfunction

endpackage

// File: rtl/dctl_mode_decode.sv
module dctl_mode_decode
    import dctl_pkg::*;
(
    input  logic      soff,
    input  logic      secure,
    output acc_mode_t mode
);
    always_comb mode = classify(soff, secure);
endmodule

// File: rtl/dctl_write_path.sv
module dctl_write_path
    import dctl_pkg::*;
(
    input  word_t     cur,
    input  acc_mode_t mode,
    input  word_t     data,
    output word_t     nxt
);
    word_t mask;
    word_t merged;

    always_comb begin
        mask   = write_mask(mode);
        merged = (cur & ~mask) | (data & mask);
        nxt    = merged;
        // entering single-state mode kills the dependent bits in the same update
        if (mode == MODE_SEC && data[B_SOFF]) begin
            nxt[B_G1S]  = 1'b0;
            nxt[B_ARENS] = 1'b0;
        end
    end
endmodule

// File: rtl/dctl_read_view.sv
module dctl_read_view
    import dctl_pkg::*;
(
    input  word_t     cur,
    input  acc_mode_t mode,
    output word_t     view
);
    always_comb view = cur & view_mask(mode);
endmodule

// File: rtl/dctl_state_reg.sv
module dctl_state_reg
    import dctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t nxt,
    output word_t cur,
    output logic  pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= reset_image();
            pulse <= 1'b0;
        end else begin
            pulse <= wr_en;
            if (wr_en) cur <= nxt;
        end
    end
endmodule

// File: rtl/dist_ctl_reg.sv
module dist_ctl_reg
    import dctl_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_secure,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_secure,
    output logic [DW-1:0] rd_data,
    output logic          upd_pulse,
    output logic          grp0_en,
    output logic          grp1ns_en,
    output logic          grp1s_en,
    output logic          sec_off
);
    word_t      img;
    word_t      img_nxt;
    word_t      view;
    acc_mode_t  wmode;
    acc_mode_t  rmode;
    ctl_flags_t flags;

    dctl_mode_decode u_wdec (.soff(img[B_SOFF]), .secure(wr_secure), .mode(wmode));
    dctl_mode_decode u_rdec (.soff(img[B_SOFF]), .secure(rd_secure), .mode(rmode));

    dctl_write_path u_wp (.cur(img), .mode(wmode), .data(wr_data), .nxt(img_nxt));

    dctl_state_reg u_st (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .nxt(img_nxt), .cur(img), .pulse(upd_pulse)
    );

    dctl_read_view u_rv (.cur(img), .mode(rmode), .view(view));

    always_comb begin
        flags.g0   = img[B_G0];
        flags.g1ns = img[B_G1NS];
        flags.g1s  = img[B_G1S];
        flags.soff = img[B_SOFF];
    end

    assign rd_data   = view;
    assign grp0_en   = flags.g0;
    assign grp1ns_en = flags.g1ns;
    assign grp1s_en  = flags.g1s;
    assign sec_off   = flags.soff;
endmodule

// File: rtl/dist_ctl_reg_chk.sv
module dist_ctl_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        wr_secure,
    input logic        rd_secure,
    input logic [31:0] rd_data,
    input logic        upd_pulse,
    input logic        grp0_en,
    input logic        grp1s_en,
    input logic        sec_off
);
    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    AST_SOFF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (live && sec_off) |=> sec_off); // R6

    AST_SOFF_CLEARS_G1S: assert property (@(posedge clk) disable iff (rst)
        live |-> !(sec_off && grp1s_en)); // R5

    AST_NS_WRITE_NARROW: assert property (@(posedge clk) disable iff (rst)
        (live && wr_en && !wr_secure && !sec_off) |=>
            ($stable(grp0_en) && $stable(grp1s_en) && !sec_off)); // R3

    AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (live && wr_en) |=> upd_pulse); // R9

    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (live && !wr_en) |=> !upd_pulse); // R9

    AST_PEND_ZERO: assert property (@(posedge clk) disable iff (rst)
        live |-> !rd_data[31]); // R10

    AST_NS_VIEW: assert property (@(posedge clk) disable iff (rst)
        (live && !rd_secure && !sec_off) |-> ((rd_data & ~32'h8000_0012) == 32'h0)); // R4

    AST_ARES_ONE: assert property (@(posedge clk) disable iff (rst)
        live |-> rd_data[4]); // R8
endmodule

bind dist_ctl_reg dist_ctl_reg_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_secure(wr_secure),
    .rd_secure(rd_secure), .rd_data(rd_data), .upd_pulse(upd_pulse),
    .grp0_en(grp0_en), .grp1s_en(grp1s_en), .sec_off(sec_off)
);

// File: tb/dist_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module dist_ctl_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_secure = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_secure = 1'b1;
    logic [31:0] rd_data;
    logic        upd_pulse, grp0_en, grp1ns_en, grp1s_en, sec_off;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    bit m_g0, m_g1ns, m_g1s, m_soff, m_pulse;

    always #2 clk = ~clk;  // 250 MHz

    dist_ctl_reg dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_secure(wr_secure),
        .wr_data(wr_data), .rd_secure(rd_secure), .rd_data(rd_data),
        .upd_pulse(upd_pulse), .grp0_en(grp0_en), .grp1ns_en(grp1ns_en),
        .grp1s_en(grp1s_en), .sec_off(sec_off)
    );

    function automatic logic [31:0] exp_view(bit sec);
        logic [31:0] v;
        v = 32'h0;
        v[4] = 1'b1;
        if (m_soff) begin
            v[0] = m_g0; v[1] = m_g1ns; v[6] = 1'b1;
        end else if (sec) begin
            v[0] = m_g0; v[1] = m_g1ns; v[2] = m_g1s; v[5] = 1'b1;
        end else begin
            v[1] = m_g1ns;
        end
        return v;
    endfunction

    task automatic compare(string tag);
        logic [31:0] ev;
        logic [3:0]  eo, ao;
        ev = exp_view(rd_secure);
        eo = {m_soff, m_g1s, m_g1ns, m_g0};
        ao = {sec_off, grp1s_en, grp1ns_en, grp0_en};
        n_cmp++;
        if (rd_data !== ev) begin
            n_bad++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, ev);
        end
        n_cmp++;
        if (upd_pulse !== m_pulse) begin
            n_bad++;
            $display("FAIL %s/R9 upd_pulse actual=%b expected=%b", tag, upd_pulse, m_pulse);
        end
        n_cmp++;
        if (ao !== eo) begin
            n_bad++;
            $display("FAIL %s/R11 flags actual=%b expected=%b", tag, ao, eo);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(bit we, bit ws, logic [31:0] d, bit rs, string tag);
        wr_en = we; wr_secure = ws; wr_data = d; rd_secure = rs;
        @(posedge clk);
        m_pulse = we;
        if (we) begin
            if (m_soff) begin
                m_g0 = d[0]; m_g1ns = d[1];
            end else if (ws) begin
                m_g0 = d[0]; m_g1ns = d[1]; m_g1s = d[2];
                if (d[6]) begin m_soff = 1'b1; m_g1s = 1'b0; end
            end else begin
                m_g1ns = d[1];
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        m_g0 = 0; m_g1ns = 0; m_g1s = 0; m_soff = 0; m_pulse = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        cyc(0, 0, 0, 1, "R1 secure reset view 0x30");
        cyc(0, 0, 0, 0, "R1/R4 ns reset view");
        cyc(1, 1, 32'hFFFF_FFB7, 1, "R2 secure write enables, bit6 clear");
        cyc(0, 0, 0, 0, "R4/R10 ns view masks bits");
        cyc(0, 0, 0, 1, "R8 ARE bits on secure view");
        cyc(1, 0, 32'hFFFF_FFFD, 1, "R3 ns write all-but-bit1");
        cyc(1, 0, 32'h0000_0002, 1, "R3 ns write sets bit1");
        cyc(1, 0, 32'h0000_0040, 1, "R3 ns write cannot set bit6");
        cyc(1, 1, 32'h0000_0000, 1, "R2 secure clear");
        cyc(1, 1, 32'h0000_0005, 1, "R2 secure write 0x5");
        cyc(0, 1, 32'hFFFF_FFFF, 1, "R9 idle no pulse");
        cyc(1, 1, 32'h0000_0047, 1, "R5 set security-off with bit2");
        cyc(0, 0, 0, 0, "R7 ns view after security-off");
        cyc(1, 1, 32'h0000_0004, 1, "R6 bit6=0 and bit2 ignored");
        cyc(1, 0, 32'h0000_0003, 0, "R6 ns write bits0/1 in single mode");
        cyc(1, 1, 32'hFFFF_FFFF, 1, "R10 all-ones write");
        cyc(1, 0, 32'h0000_0003, 1, "R9 no-change write still pulses");
        do_reset();
        cyc(0, 0, 0, 1, "R1 reset clears security-off");
        cyc(1, 1, 32'h0000_0044, 0, "R5 ns view after flag set");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule